// File: doc/BRIEF.md
# Core Voltage Reference Sequencer

This block produces the digital reference target, in millivolts, for the control loop of a buck regulator that feeds a processor core. A 5-bit voltage-identification code is translated into a set point through a two-segment, descending map. While the regulator is being brought up, the reference climbs in two stages. It first rises slowly to a fixed knee. It then follows the requested set point at a fast slew rate. From that point on, every change of the code or of the alternate set point moves the reference up or down at the same fast rate. Each move ends exactly on the new value.

An alternate set point can replace the decoded code. The system uses it when the processor cannot yet drive a valid code, for example during power-up or a deep sleep state. The regulator needs both an enable input and a supply-good input. Losing either one drops the reference to zero and re-arms the soft start. The analog converter, the error amplifier and the timing capacitor are not modelled. One clock tick stands for one integer step in millivolts.

Top module: `vref_sequencer`

## Requirements
- R1: For codes 0 to 15 the decoded set point is 1750 mV minus 50 mV per code, so code 0 gives 1750 mV and code 15 gives 1000 mV.
- R2: For codes 16 to 31 the decoded set point is 975 mV minus 25 mV per code above 16, so code 31 gives 600 mV. Code 31 is the all-ones pattern that open, pulled-up code inputs produce.
- R3: While `en_i` or `pgood_i` is low, `ref_mv_o`, `ss_done_o` and `busy_o` are 0 at every clock. If either input falls during operation, the reference is 0 after the next rising edge.
- R4: During soft start the reference rises by exactly SLOW_STEP_MV (default 5) per clock from 0. It never falls. It stops at KNEE_MV (default 500). The first step happens at the first edge where both enables are high.
- R5: `ss_done_o` rises at the same edge at which the reference reaches KNEE_MV. It then stays high for as long as both enables stay high, whatever the target is.
- R6: After soft start, the reference moves toward the target by the fast step at each clock, upward or downward. When the remaining distance is no larger than the step, it lands exactly on the target. It never overshoots.
- R7: The fast step is `rate_step_i` in mV per clock when that input is nonzero. When it is zero, the step is FAST_STEP_MV (default 100, twenty times the slow step).
- R8: When `alt_sel_i` is high and `alt_mv_i` is below 1750, the target is `alt_mv_i`. When `alt_mv_i` is 1750 or more, or when `alt_sel_i` is low, the target is the decoded code.
- R9: `busy_o` is high exactly when `ss_done_o` is high and `ref_mv_o` differs from the current target. It follows a change of the target in the same cycle, without waiting for a clock.
- R10: A synchronous active-low `rst_n` clears the reference and the soft-start state at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge is one ramp tick |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Regulator enable |
| pgood_i | input | 1 | Bias supply good |
| vid_i | input | 5 | Voltage-identification code |
| alt_sel_i | input | 1 | Selects the alternate set point |
| alt_mv_i | input | REF_W (12) | Alternate set point in mV |
| rate_step_i | input | STEP_W (8) | Fast slew step in mV per clock; 0 selects the default |
| ref_mv_o | output | REF_W (12) | Current reference in mV |
| ss_done_o | output | 1 | Soft start complete |
| busy_o | output | 1 | Reference still moving toward the target |

## Verification
The assertions assume that all inputs change only between rising edges. They also assume that the reference plus one step always fits in REF_W bits, which holds while `alt_mv_i` and `rate_step_i` stay inside their declared widths. The step-size property takes the fast step from the value of `rate_step_i` one edge earlier, so it relies on the step input being steady at the sampling edge. The stimulus drives every input just after a falling edge. It keeps the alternate value between 300 and 1800 mV, and it holds or changes the rate only across whole cycles, so every sampled edge sees settled values.

// File: rtl/vref_pkg.sv
// Shared types and constants for the core voltage reference sequencer.
// Assumes millivolt quantities are unsigned integers.
package vref_pkg;

    localparam int unsigned VID_W = 5;

    // Ramp engine state: off, slow soft-start climb, fast tracking.
    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_SOFT  = 2'd1,
        PH_TRACK = 2'd2
    } ramp_phase_e;

endpackage

// File: rtl/vref_vid_decode.sv
// Translates a voltage-identification code into a set point in mV.
// The upper half of the code space (MSB set) uses the fine segment, the
// lower half the coarse one; both descend as the code value grows.
// Assumes REF_W holds TOP_MV.
module vref_vid_decode #(
    parameter int unsigned REF_W     = 12,
    parameter int unsigned VID_W     = vref_pkg::VID_W,
    parameter int unsigned TOP_MV    = 1750,
    parameter int unsigned COARSE_MV = 50,
    parameter int unsigned MID_MV    = 975,
    parameter int unsigned FINE_MV   = 25
) (
    input  logic [VID_W-1:0] code_i,
    output logic [REF_W-1:0] mv_o
);
    localparam int unsigned IDX_W = VID_W - 1;

    logic [IDX_W-1:0] idx;
    logic             fine_seg;
    logic [REF_W-1:0] base_mv;
    logic [REF_W-1:0] pitch_mv;

    assign idx      = code_i[IDX_W-1:0];
    assign fine_seg = code_i[VID_W-1];

    // Select segment base and pitch from the code MSB.
    always_comb begin
        if (fine_seg) begin
            base_mv  = REF_W'(MID_MV);
            pitch_mv = REF_W'(FINE_MV);
        end else begin
            base_mv  = REF_W'(TOP_MV);
            pitch_mv = REF_W'(COARSE_MV);
        end
    end

    // Descend from the segment base by one pitch per index step.
    always_comb begin
        mv_o = base_mv - REF_W'(pitch_mv * REF_W'(idx));
    end

endmodule

// File: rtl/vref_target_mux.sv
// Chooses the regulation target: the alternate set point when selected
// and below ALT_LIMIT_MV, otherwise the decoded code.
// Assumes both candidates are in mV with the same width.
module vref_target_mux #(
    parameter int unsigned REF_W        = 12,
    parameter int unsigned ALT_LIMIT_MV = 1750
) (
    input  logic             alt_sel_i,
    input  logic [REF_W-1:0] alt_mv_i,
    input  logic [REF_W-1:0] vid_mv_i,
    output logic [REF_W-1:0] tgt_mv_o
);
    logic alt_in_range;

    // Alternate value is honoured only below the highest code voltage.
    assign alt_in_range = alt_mv_i < REF_W'(ALT_LIMIT_MV);

    // Override multiplexer.
    always_comb begin
        if (alt_sel_i && alt_in_range) begin
            tgt_mv_o = alt_mv_i;
        end else begin
            tgt_mv_o = vid_mv_i;
        end
    end

endmodule

// File: rtl/vref_slew_engine.sv
// Holds the reference register and walks it: a slow climb from zero to
// KNEE_MV, then bidirectional fast tracking of the target with an exact
// landing. A low run_i clears it. Assumes ref plus one step fits REF_W.
module vref_slew_engine #(
    parameter int unsigned REF_W        = 12,
    parameter int unsigned STEP_W       = 8,
    parameter int unsigned SLOW_STEP_MV = 5,
    parameter int unsigned FAST_STEP_MV = 100,
    parameter int unsigned KNEE_MV      = 500
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_i,
    input  logic [REF_W-1:0]       tgt_i,
    input  logic [STEP_W-1:0]      rate_step_i,
    output logic [REF_W-1:0]       ref_o,
    output vref_pkg::ramp_phase_e  phase_o
);
    import vref_pkg::*;

    localparam int unsigned SUM_W = REF_W + 1;

    ramp_phase_e      phase_q, phase_d;
    logic [REF_W-1:0] ref_q, ref_d;
    logic [REF_W-1:0] fast_step;
    logic [SUM_W-1:0] soft_sum;
    logic [REF_W-1:0] gap_up, gap_dn;

    // Effective fast step: input value, or the default when zero.
    always_comb begin
        if (rate_step_i != '0) fast_step = REF_W'(rate_step_i);
        else                   fast_step = REF_W'(FAST_STEP_MV);
    end

    // Candidate soft-start value and distances to the target.
    assign soft_sum = SUM_W'(ref_q) + SUM_W'(SLOW_STEP_MV);
    assign gap_up   = tgt_i - ref_q;
    assign gap_dn   = ref_q - tgt_i;

    // Next-state selection for the phase and the reference.
    always_comb begin
        phase_d = phase_q;
        ref_d   = ref_q;
        if (!run_i) begin
            phase_d = PH_OFF;
            ref_d   = '0;
        end else if (phase_q != PH_TRACK) begin
            if (soft_sum >= SUM_W'(KNEE_MV)) begin
                phase_d = PH_TRACK;
                ref_d   = REF_W'(KNEE_MV);
            end else begin
                phase_d = PH_SOFT;
                ref_d   = soft_sum[REF_W-1:0];
            end
        end else if (ref_q < tgt_i) begin
            ref_d = (gap_up <= fast_step) ? tgt_i : ref_q + fast_step;
        end else if (ref_q > tgt_i) begin
            ref_d = (gap_dn <= fast_step) ? tgt_i : ref_q - fast_step;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OFF;
            ref_q   <= '0;
        end else begin
            phase_q <= phase_d;
            ref_q   <= ref_d;
        end
    end

    assign ref_o   = ref_q;
    assign phase_o = phase_q;

endmodule

// File: rtl/vref_sequencer.sv
// Top of the core voltage reference sequencer: decodes the code, applies
// the alternate override and drives the slew engine. The busy flag is
// combinational so it reacts to a target change in the same cycle.
// Assumes inputs are synchronous to clk.
module vref_sequencer #(
    parameter int unsigned REF_W        = 12,
    parameter int unsigned STEP_W       = 8,
    parameter int unsigned SLOW_STEP_MV = 5,
    parameter int unsigned FAST_STEP_MV = 100,
    parameter int unsigned KNEE_MV      = 500,
    parameter int unsigned TOP_MV       = 1750
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en_i,
    input  logic                        pgood_i,
    input  logic [vref_pkg::VID_W-1:0]  vid_i,
    input  logic                        alt_sel_i,
    input  logic [REF_W-1:0]            alt_mv_i,
    input  logic [STEP_W-1:0]           rate_step_i,
    output logic [REF_W-1:0]            ref_mv_o,
    output logic                        ss_done_o,
    output logic                        busy_o
);
    import vref_pkg::*;

    logic [REF_W-1:0] vid_mv;
    logic [REF_W-1:0] tgt_mv;
    logic             run;
    ramp_phase_e      phase;

    // Operation needs both the enable and the supply-good input.
    assign run = en_i & pgood_i;

    vref_vid_decode #(
        .REF_W  (REF_W),
        .VID_W  (VID_W),
        .TOP_MV (TOP_MV)
    ) u_decode (
        .code_i (vid_i),
        .mv_o   (vid_mv)
    );

    vref_target_mux #(
        .REF_W        (REF_W),
        .ALT_LIMIT_MV (TOP_MV)
    ) u_mux (
        .alt_sel_i (alt_sel_i),
        .alt_mv_i  (alt_mv_i),
        .vid_mv_i  (vid_mv),
        .tgt_mv_o  (tgt_mv)
    );

    vref_slew_engine #(
        .REF_W        (REF_W),
        .STEP_W       (STEP_W),
        .SLOW_STEP_MV (SLOW_STEP_MV),
        .FAST_STEP_MV (FAST_STEP_MV),
        .KNEE_MV      (KNEE_MV)
    ) u_slew (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .tgt_i       (tgt_mv),
        .rate_step_i (rate_step_i),
        .ref_o       (ref_mv_o),
        .phase_o     (phase)
    );

    // Status outputs derived from the engine phase and the live target.
    assign ss_done_o = (phase == PH_TRACK);
    assign busy_o    = ss_done_o && (ref_mv_o != tgt_mv);

endmodule

// File: rtl/vref_sequencer_chk.sv
// Property checker for vref_sequencer, attached by bind below.
// Assumes inputs settle between rising edges.
module vref_sequencer_chk #(
    parameter int unsigned REF_W        = 12,
    parameter int unsigned STEP_W       = 8,
    parameter int unsigned SLOW_STEP_MV = 5,
    parameter int unsigned FAST_STEP_MV = 100,
    parameter int unsigned KNEE_MV      = 500
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              pgood_i,
    input logic [STEP_W-1:0] rate_step_i,
    input logic [REF_W-1:0]  ref_mv_o,
    input logic              ss_done_o,
    input logic              busy_o,
    input logic [REF_W-1:0]  tgt_mv
);
    logic     up_run;
    int       step_lim;
    int       ref_i;

    assign up_run   = en_i && pgood_i;
    assign step_lim = (rate_step_i != '0) ? int'(rate_step_i) : int'(FAST_STEP_MV);
    assign ref_i    = int'(ref_mv_o);

    // R3: losing either enable clears the outputs at the next edge.
    p_drop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !up_run |=> (ref_mv_o == '0 && !ss_done_o && !busy_o));

    // R4: soft-start climb is monotonic and bounded by the slow step.
    p_slow_climb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_run && !ss_done_o) |=>
            (ref_i >= $past(ref_i)) && (ref_i - $past(ref_i) <= int'(SLOW_STEP_MV))
            && (ref_i <= int'(KNEE_MV)));

    // R5: completion stays set while running.
    p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_run && ss_done_o) |=> ss_done_o);

    // R6/R7: tracking moves by at most one fast step.
    p_fast_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_run && ss_done_o) |=>
            (((ref_i >= $past(ref_i)) ? (ref_i - $past(ref_i)) : ($past(ref_i) - ref_i))
             <= $past(step_lim)));

    // R6: a climb toward the target never passes it.
    p_no_overshoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_run && ss_done_o && ref_mv_o <= tgt_mv) |=> (ref_mv_o <= $past(tgt_mv)));

    // R9: a settled reference holds its value.
    p_settled_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_run && ss_done_o && !busy_o) |=> $stable(ref_mv_o));

    // R10: reset clears the reference at the next edge.
    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (ref_mv_o == '0 && !ss_done_o));

endmodule

bind vref_sequencer vref_sequencer_chk #(
    .REF_W        (REF_W),
    .STEP_W       (STEP_W),
    .SLOW_STEP_MV (SLOW_STEP_MV),
    .FAST_STEP_MV (FAST_STEP_MV),
    .KNEE_MV      (KNEE_MV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .pgood_i     (pgood_i),
    .rate_step_i (rate_step_i),
    .ref_mv_o    (ref_mv_o),
    .ss_done_o   (ss_done_o),
    .busy_o      (busy_o),
    .tgt_mv      (tgt_mv)
);

// File: tb/vref_sequencer_tb_top.sv
`timescale 1ns/100ps
// Bench for vref_sequencer: a behavioural reference model stepped on every
// rising edge and compared with the outputs at every falling edge.
module vref_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en_i, pgood_i, alt_sel_i;
    logic [4:0]  vid_i;
    logic [11:0] alt_mv_i;
    logic [7:0]  rate_step_i;
    logic [11:0] ref_mv_o;
    logic        ss_done_o, busy_o;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    // Model state.
    int m_ref = 0;
    bit m_done = 0;
    int vid_tab[32];
    string cur_tag = "R10";

    always #2.5 clk = ~clk;

    vref_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .pgood_i(pgood_i),
        .vid_i(vid_i), .alt_sel_i(alt_sel_i), .alt_mv_i(alt_mv_i),
        .rate_step_i(rate_step_i), .ref_mv_o(ref_mv_o),
        .ss_done_o(ss_done_o), .busy_o(busy_o)
    );

    function automatic int model_target();
        if (alt_sel_i && alt_mv_i < 1750) return int'(alt_mv_i);
        return vid_tab[vid_i];
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            report();
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One clock: advance the model at the edge, compare after it.
    task automatic tick();
        int tgt, stp;
        @(posedge clk);
        tgt = model_target();
        stp = (rate_step_i != 0) ? int'(rate_step_i) : 100;
        if (!rst_n || !en_i || !pgood_i) begin
            m_ref = 0; m_done = 0;
        end else if (!m_done) begin
            m_ref += 5;
            if (m_ref >= 500) begin m_ref = 500; m_done = 1; end
        end else if (m_ref < tgt) begin
            m_ref = (tgt - m_ref <= stp) ? tgt : m_ref + stp;
        end else if (m_ref > tgt) begin
            m_ref = (m_ref - tgt <= stp) ? tgt : m_ref - stp;
        end
        @(negedge clk);
        check_eq({cur_tag, " ref"}, int'(ref_mv_o), m_ref);
        check_eq({cur_tag, " done"}, int'(ss_done_o), int'(m_done));
        check_eq({cur_tag, " busy (R9)"}, int'(busy_o), int'(m_done && m_ref != model_target()));
    endtask

    task automatic settle(input string tag);
        cur_tag = tag;
        for (int k = 0; k < 400; k++) begin
            tick();
            if (m_done && m_ref == model_target()) break;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) vid_tab[i] = 1750 - 50 * i;
        for (int i = 16; i < 32; i++) vid_tab[i] = 975 - 25 * (i - 16);

        rst_n = 0; en_i = 0; pgood_i = 0; vid_i = 5'd0;
        alt_sel_i = 0; alt_mv_i = 12'd0; rate_step_i = 8'd0;

        // R10: reset state.
        cur_tag = "R10";
        repeat (3) tick();
        check_eq("R10 reset ref", int'(ref_mv_o), 0);

        // R3: released but not enabled, then only one enable high.
        rst_n = 1; cur_tag = "R3";
        repeat (3) tick();
        en_i = 1;
        repeat (3) tick();
        check_eq("R3 pgood low ref", int'(ref_mv_o), 0);

        // R4/R5: slow climb to the knee, then fast to code 0 (R1, 1750).
        pgood_i = 1; cur_tag = "R4";
        tick();
        check_eq("R4 first step", int'(ref_mv_o), 5);
        for (int k = 0; k < 98; k++) tick();
        check_eq("R5 not yet done", int'(ss_done_o), 0);
        tick();
        check_eq("R5 done at knee", int'(ss_done_o), 1);
        check_eq("R4 knee value", int'(ref_mv_o), 500);
        cur_tag = "R6";
        tick();
        check_eq("R6 first fast step", int'(ref_mv_o), 600);
        settle("R6");
        check_eq("R1 code 0", int'(ref_mv_o), 1750);

        // R1/R2: every code, downward and upward moves with the default step.
        for (int c = 0; c < 32; c++) begin
            vid_i = 5'(c);
            settle(c < 16 ? "R1" : "R2");
            check_eq(c < 16 ? "R1 map" : "R2 map", int'(ref_mv_o),
                     c < 16 ? 1750 - 50 * c : 975 - 25 * (c - 16));
        end
        check_eq("R2 open inputs 600", int'(ref_mv_o), 600);

        // R7: programmed step 7, up from 600 to 1750.
        rate_step_i = 8'd7; vid_i = 5'd0; cur_tag = "R7";
        tick();
        check_eq("R7 step 7 up", int'(ref_mv_o), 607);
        settle("R7");
        check_eq("R7 exact landing", int'(ref_mv_o), 1750);
        rate_step_i = 8'd33; vid_i = 5'd31; cur_tag = "R7";
        tick();
        check_eq("R7 step 33 down", int'(ref_mv_o), 1717);
        settle("R6");
        check_eq("R6 exact landing down", int'(ref_mv_o), 600);
        rate_step_i = 8'd0;

        // R8: alternate override, limit and deselect.
        alt_sel_i = 1; alt_mv_i = 12'd1200;
        settle("R8");
        check_eq("R8 alt 1200", int'(ref_mv_o), 1200);
        alt_mv_i = 12'd1750;
        settle("R8");
        check_eq("R8 alt at limit ignored", int'(ref_mv_o), 600);
        alt_mv_i = 12'd1800;
        settle("R8");
        check_eq("R8 alt above limit ignored", int'(ref_mv_o), 600);
        alt_mv_i = 12'd1749;
        settle("R8");
        check_eq("R8 alt 1749", int'(ref_mv_o), 1749);
        alt_sel_i = 0;
        settle("R8");
        check_eq("R8 deselect returns to code", int'(ref_mv_o), 600);

        // R9: busy follows a target change without a clock edge.
        vid_i = 5'd10;
        #0.5;
        check_eq("R9 busy same cycle", int'(busy_o), 1);
        settle("R9");

        // R3: supply-good drop clears on the next edge.
        pgood_i = 0; cur_tag = "R3";
        tick();
        check_eq("R3 pgood drop ref", int'(ref_mv_o), 0);
        pgood_i = 1; cur_tag = "R4";
        repeat (40) tick();
        en_i = 0; cur_tag = "R3";
        tick();
        check_eq("R3 enable drop mid soft start", int'(ref_mv_o), 0);

        // R5/R6: alternate target below the knee; climb to knee then fall.
        en_i = 1; alt_sel_i = 1; alt_mv_i = 12'd300; cur_tag = "R5";
        for (int k = 0; k < 100; k++) tick();
        check_eq("R5 knee before low target", int'(ref_mv_o), 500);
        settle("R6");
        check_eq("R6 low alt target", int'(ref_mv_o), 300);
        check_eq("R5 done kept", int'(ss_done_o), 1);

        // R10: reset while running.
        rst_n = 0; cur_tag = "R10";
        tick();
        check_eq("R10 reset mid run", int'(ref_mv_o), 0);
        rst_n = 1;
        repeat (4) tick();

        report();
    end

endmodule